// File: doc/BRIEF.md
# Second-Stage Translation Walker with Accessed/Dirty Tracking

This block walks a four-level second-stage translation table for a DMA remapping unit. A request supplies an input address, a write/read indication, the table root and the flag word of the owning PASID entry. The walker fetches one 64-bit entry per level over a single-outstanding memory port. It narrows the read and write permissions at each level and stops at the leaf entry. It then reports the leaf entry, the level at which the walk stopped and the surviving permissions. If a memory access returns an error, it reports a fault code instead.

When the PASID flags enable tracking, the walker updates the leaf's Accessed and Dirty flags in place. It writes the modified entry back, reads it again, and returns the value it read. A separate output carries the extended-capability word. That word advertises tracking support only while scalable mode is on.

Top module: `s2_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. After reset, `req_ready` is 1, `done` is 0 and `mem_req_valid` is 0.
- R2: The root table base is `req_root` with bits [11:0] cleared. Each next-level base is the fetched entry with bits [11:0] cleared. The entry address is base + index × 8. The index for level 4, 3, 2 and 1 is taken from address bits [47:39], [38:30], [29:21] and [20:12] respectively.
- R3: Entry bit 0 grants read and bit 1 grants write. The reported permissions are the AND of those bits over every entry fetched.
- R4: A fetched entry is a leaf when the walk is at level 1, or when bit 7 is set at level 2 or 3. Bit 7 is ignored at level 4. A successful walk reports levels 1 to 3 only.
- R5: When bit 9 of `req_pe_flags` is clear, the leaf is never modified or written back.
- R6: With tracking enabled, Dirty (entry bit 9) is set only when three conditions hold: the request is a write, write permission survived the walk, and Dirty is currently 0.
- R7: With tracking enabled, Accessed (entry bit 8) is set when it is currently 0 and either of two things is true: the request is a read with read permission surviving, or Dirty was set by this request.
- R8: A write-back happens only when the Accessed or Dirty flag changed. It is followed by a read of the same address, and `res_entry` is the value that read returned.
- R9: An error response ends the walk with `res_fault`=1, `res_entry`=0 and both permissions 0. The fault code is 1 (context entry invalid) for an error on the level-4 fetch. It is 2 (paging entry invalid) for an error on any lower-level fetch, on the write-back, or on the read-back. `res_level` is the level at which the error happened.
- R10: `ext_cap` bit 45 equals `scalable_en`, and every other bit is 0.
- R11: At most one memory transaction is outstanding: after a request is accepted, `mem_req_valid` stays low until its response arrives. `done` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| scalable_en | input | 1 | Scalable translation mode is enabled |
| ext_cap | output | 64 | Extended capability word |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_addr | input | 48 | Input address to translate |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_pe_flags | input | 16 | PASID-entry flags; bit 9 enables A/D tracking |
| req_root | input | 64 | Root table pointer |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 64 | Write data |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_data | input | 64 | Read data |
| mem_rsp_err | input | 1 | Response carries an error |
| done | output | 1 | One-cycle result strobe |
| res_fault | output | 1 | Walk ended in a fault |
| res_fault_code | output | 2 | 0 none, 1 context entry invalid, 2 paging entry invalid |
| res_entry | output | 64 | Final leaf entry |
| res_level | output | 3 | Level at which the walk ended |
| res_read | output | 1 | Read permission granted |
| res_write | output | 1 | Write permission granted |

## Verification
A level counter that is off by one shows up within two cycles as a wrong `mem_addr` index. It then produces a wrong `res_level` at the `done` strobe. A stuck or wrongly sequenced state register changes the cycle in which `mem_req_valid`, `req_ready` or `done` rises, so the reference model compares these signals on every clock. A wrong A/D decision only becomes visible in the leaf's stored value after the walk and in `res_entry`. For that reason the bench also checks table memory after each walk.

// File: rtl/s2w_pkg.sv
package s2w_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} walk_st_e;
  typedef enum logic [1:0] {OP_FETCH, OP_WB, OP_RB} mem_op_e;

  localparam int unsigned BIT_R      = 0;
  localparam int unsigned BIT_W      = 1;
  localparam int unsigned BIT_LEAF   = 7;
  localparam int unsigned BIT_ACC    = 8;
  localparam int unsigned BIT_DIRTY  = 9;
  localparam int unsigned PE_ADE_BIT = 9;
  localparam int unsigned CAP_AD_BIT = 45;

  localparam logic [1:0] FLT_NONE = 2'd0;
  localparam logic [1:0] FLT_CTX  = 2'd1;
  localparam logic [1:0] FLT_PG   = 2'd2;
endpackage

// File: rtl/s2w_level_index.sv
module s2w_level_index #(
  parameter int unsigned ADDR_W     = 48,
  parameter int unsigned LEVELS     = 4,
  parameter int unsigned IDX_W      = 9,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned LVL_W      = 3
) (
  input  logic [ADDR_W-1:0] va,
  input  logic [LVL_W-1:0]  level,
  output logic [IDX_W-1:0]  idx
);
  logic [IDX_W-1:0] slice [LEVELS];
  logic             unused_low;

  assign unused_low = ^va[PAGE_SHIFT-1:0];

  for (genvar l = 0; l < LEVELS; l++) begin : g_slice
    assign slice[l] = va[PAGE_SHIFT + IDX_W*l +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (level == LVL_W'(l + 1)) idx = slice[l];
    end
  end
endmodule

// File: rtl/s2w_ad_update.sv
module s2w_ad_update
  import s2w_pkg::*;
#(
  parameter int unsigned ENTRY_W = 64
) (
  input  logic [ENTRY_W-1:0] entry_in,
  input  logic               ad_en,
  input  logic               is_write,
  input  logic               rd_ok,
  input  logic               wr_ok,
  output logic [ENTRY_W-1:0] entry_out,
  output logic               changed
);
  logic set_d, set_a;

  always_comb begin
    set_d     = ad_en & is_write & wr_ok & ~entry_in[BIT_DIRTY];
    set_a     = ad_en & ~entry_in[BIT_ACC] & ((~is_write & rd_ok) | set_d);
    entry_out = entry_in;
    if (set_d) entry_out[BIT_DIRTY] = 1'b1;
    if (set_a) entry_out[BIT_ACC]   = 1'b1;
    changed   = set_d | set_a;
  end
endmodule

// File: rtl/s2_walker.sv
module s2_walker
  import s2w_pkg::*;
#(
  parameter int unsigned ADDR_W     = 48,
  parameter int unsigned PA_W       = 64,
  parameter int unsigned ENTRY_W    = 64,
  parameter int unsigned LEVELS     = 4,
  parameter int unsigned IDX_W      = 9,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned FLAGS_W    = 16,
  parameter int unsigned LVL_W      = $clog2(LEVELS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scalable_en,
  output logic [63:0]         ext_cap,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_write,
  input  logic [FLAGS_W-1:0]  req_pe_flags,
  input  logic [PA_W-1:0]     req_root,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_we,
  output logic [PA_W-1:0]     mem_addr,
  output logic [ENTRY_W-1:0]  mem_wdata,
  input  logic                mem_rsp_valid,
  input  logic [ENTRY_W-1:0]  mem_rsp_data,
  input  logic                mem_rsp_err,
  output logic                done,
  output logic                res_fault,
  output logic [1:0]          res_fault_code,
  output logic [ENTRY_W-1:0]  res_entry,
  output logic [LVL_W-1:0]    res_level,
  output logic                res_read,
  output logic                res_write
);
  localparam logic [PA_W-1:0]  BASE_MASK = ~((PA_W'(1) << PAGE_SHIFT) - PA_W'(1));
  localparam logic [LVL_W-1:0] TOP_LVL   = LVL_W'(LEVELS);

  walk_st_e             state_q, state_n;
  mem_op_e              op_q, op_n;
  logic [LVL_W-1:0]     level_q, level_n;
  logic [PA_W-1:0]      base_q, base_n;
  logic [ADDR_W-1:0]    va_q, va_n;
  logic                 wr_q, wr_n, ade_q, ade_n;
  logic                 rdok_q, rdok_n, wrok_q, wrok_n;
  logic [ENTRY_W-1:0]   wdata_q, wdata_n;
  logic                 flt_q, flt_n, rr_q, rr_n, rw_q, rw_n;
  logic [1:0]           code_q, code_n;
  logic [ENTRY_W-1:0]   ent_q, ent_n;
  logic [LVL_W-1:0]     rlvl_q, rlvl_n;

  logic [IDX_W-1:0]     idx;
  logic [ENTRY_W-1:0]   ad_entry;
  logic                 ad_changed, acc_rd, acc_wr, is_leaf;
  logic [FLAGS_W-1:0]   unused_flags;

  assign unused_flags = req_pe_flags;

  s2w_level_index #(
    .ADDR_W(ADDR_W), .LEVELS(LEVELS), .IDX_W(IDX_W),
    .PAGE_SHIFT(PAGE_SHIFT), .LVL_W(LVL_W)
  ) u_index (.va(va_q), .level(level_q), .idx(idx));

  assign acc_rd  = rdok_q & mem_rsp_data[BIT_R];
  assign acc_wr  = wrok_q & mem_rsp_data[BIT_W];
  assign is_leaf = (level_q == LVL_W'(1)) ||
                   (mem_rsp_data[BIT_LEAF] && level_q != TOP_LVL);

  s2w_ad_update #(.ENTRY_W(ENTRY_W)) u_ad (
    .entry_in(mem_rsp_data), .ad_en(ade_q), .is_write(wr_q),
    .rd_ok(acc_rd), .wr_ok(acc_wr),
    .entry_out(ad_entry), .changed(ad_changed)
  );

  assign ext_cap       = scalable_en ? (64'd1 << CAP_AD_BIT) : 64'd0;
  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign mem_we        = (op_q == OP_WB);
  assign mem_addr      = base_q + (PA_W'(idx) << 3);
  assign mem_wdata     = wdata_q;
  assign done          = (state_q == ST_DONE);
  assign res_fault      = flt_q;
  assign res_fault_code = code_q;
  assign res_entry      = ent_q;
  assign res_level      = rlvl_q;
  assign res_read       = rr_q;
  assign res_write      = rw_q;

  always_comb begin
    state_n = state_q; op_n = op_q; level_n = level_q; base_n = base_q;
    va_n = va_q; wr_n = wr_q; ade_n = ade_q; rdok_n = rdok_q; wrok_n = wrok_q;
    wdata_n = wdata_q; flt_n = flt_q; code_n = code_q; ent_n = ent_q;
    rlvl_n = rlvl_q; rr_n = rr_q; rw_n = rw_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          va_n    = req_addr;
          wr_n    = req_write;
          ade_n   = req_pe_flags[PE_ADE_BIT];
          base_n  = req_root & BASE_MASK;
          level_n = TOP_LVL;
          rdok_n  = 1'b1;
          wrok_n  = 1'b1;
          op_n    = OP_FETCH;
          state_n = ST_ISSUE;
        end
      end
      ST_ISSUE: if (mem_req_ready) state_n = ST_WAIT;
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            flt_n   = 1'b1;
            code_n  = (op_q == OP_FETCH && level_q == TOP_LVL) ? FLT_CTX : FLT_PG;
            ent_n   = '0;
            rlvl_n  = level_q;
            rr_n    = 1'b0;
            rw_n    = 1'b0;
            state_n = ST_DONE;
          end else begin
            unique case (op_q)
              OP_FETCH: begin
                rdok_n = acc_rd;
                wrok_n = acc_wr;
                if (is_leaf) begin
                  flt_n  = 1'b0;
                  code_n = FLT_NONE;
                  rlvl_n = level_q;
                  rr_n   = acc_rd;
                  rw_n   = acc_wr;
                  if (ad_changed) begin
                    wdata_n = ad_entry;
                    op_n    = OP_WB;
                    state_n = ST_ISSUE;
                  end else begin
                    ent_n   = mem_rsp_data;
                    state_n = ST_DONE;
                  end
                end else begin
                  base_n  = mem_rsp_data & BASE_MASK;
                  level_n = level_q - LVL_W'(1);
                  state_n = ST_ISSUE;
                end
              end
              OP_WB: begin
                op_n    = OP_RB;
                state_n = ST_ISSUE;
              end
              default: begin
                ent_n   = mem_rsp_data;
                state_n = ST_DONE;
              end
            endcase
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; op_q <= OP_FETCH; level_q <= '0; base_q <= '0;
      va_q <= '0; wr_q <= 1'b0; ade_q <= 1'b0; rdok_q <= 1'b0; wrok_q <= 1'b0;
      wdata_q <= '0; flt_q <= 1'b0; code_q <= FLT_NONE; ent_q <= '0;
      rlvl_q <= '0; rr_q <= 1'b0; rw_q <= 1'b0;
    end else begin
      state_q <= state_n; op_q <= op_n; level_q <= level_n; base_q <= base_n;
      va_q <= va_n; wr_q <= wr_n; ade_q <= ade_n; rdok_q <= rdok_n; wrok_q <= wrok_n;
      wdata_q <= wdata_n; flt_q <= flt_n; code_q <= code_n; ent_q <= ent_n;
      rlvl_q <= rlvl_n; rr_q <= rr_n; rw_q <= rw_n;
    end
  end

  // R1: the walker never asks memory for data while it claims to be idle
  assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
  // R4: a completed walk never ends at the top level
  assert_leaf_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !res_fault) |-> (res_level != TOP_LVL && res_level != '0));
  // R5: a write-back only happens when the PASID flags enabled tracking
  assert_wb_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_we) |-> ade_q);
  // R8: any entry written back carries a set A or D flag
  assert_wb_changed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_we) |-> (mem_wdata[BIT_ACC] || mem_wdata[BIT_DIRTY]));
  // R9: a fault always carries one of the two defined codes
  assert_fault_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_fault) |-> (res_fault_code == FLT_CTX || res_fault_code == FLT_PG));
  // R11: after an accepted request, no new request until the response arrives
  assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);
  // R11: done lasts exactly one cycle
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/s2_walker_bench.sv
`timescale 1ns/1ps
module s2_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        scalable_en;
  logic [63:0] ext_cap;
  logic        req_valid, req_ready, req_write;
  logic [47:0] req_addr;
  logic [15:0] req_pe_flags;
  logic [63:0] req_root;
  logic        mem_req_valid, mem_req_ready, mem_we;
  logic [63:0] mem_addr, mem_wdata;
  logic        mem_rsp_valid, mem_rsp_err;
  logic [63:0] mem_rsp_data;
  logic        done, res_fault, res_read, res_write;
  logic [1:0]  res_fault_code;
  logic [63:0] res_entry;
  logic [2:0]  res_level;

  int checks = 0;
  int fails  = 0;

  logic [63:0] mem [logic [63:0]];
  logic [63:0] err_addr = 64'hFFFF_FFFF_FFFF_FFF8;
  bit          err_wr_only = 1'b0;

  always #2.5 clk = ~clk;

  s2_walker u_s2_walker (
    .clk(clk), .rst_n(rst_n), .scalable_en(scalable_en), .ext_cap(ext_cap),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_pe_flags(req_pe_flags), .req_root(req_root),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err), .done(done),
    .res_fault(res_fault), .res_fault_code(res_fault_code), .res_entry(res_entry),
    .res_level(res_level), .res_read(res_read), .res_write(res_write)
  );

  assign mem_req_ready = 1'b1;

  function automatic logic [63:0] rd_mem(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      if (mem_addr == err_addr && (!err_wr_only || mem_we)) begin
        mem_rsp_err  <= 1'b1;
        mem_rsp_data <= 64'd0;
      end else begin
        mem_rsp_err  <= 1'b0;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          mem_rsp_data <= 64'd0;
        end else begin
          mem_rsp_data <= rd_mem(mem_addr);
        end
      end
    end else begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_err   <= 1'b0;
    end
  end

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Behavioural reference: walk the bench memory without modifying it.
  task automatic model(input logic [47:0] va, input bit wr, input logic [15:0] fl,
                       input logic [63:0] root,
                       output logic [63:0] e_ent, output int e_lvl, output bit e_rd,
                       output bit e_wr, output bit e_flt, output int e_code,
                       output int e_n, output logic [63:0] e_leaf_pa);
    logic [63:0] base = root & ~64'hFFF;
    bit rd = 1, w = 1;
    e_n = 0; e_flt = 0; e_code = 0; e_ent = 0; e_rd = 0; e_wr = 0; e_leaf_pa = 0; e_lvl = 0;
    for (int lvl = 4; lvl >= 1; lvl--) begin
      logic [63:0] pa = base + (((va >> (12 + 9*(lvl-1))) & 48'h1FF) * 8);
      logic [63:0] e, ne;
      bit d;
      e_n++;
      if (pa == err_addr && !err_wr_only) begin
        e_flt = 1; e_code = (lvl == 4) ? 1 : 2; e_lvl = lvl; return;
      end
      e = rd_mem(pa);
      rd = rd & e[0];
      w  = w & e[1];
      if (lvl == 1 || (e[7] && lvl < 4)) begin
        ne = e; d = 0;
        if (fl[9]) begin
          d = wr && w && !e[9];
          if (d) ne[9] = 1'b1;
          if (((!wr && rd) || d) && !e[8]) ne[8] = 1'b1;
        end
        e_lvl = lvl; e_leaf_pa = pa;
        if (ne != e) begin
          e_n++;
          if (pa == err_addr && err_wr_only) begin
            e_flt = 1; e_code = 2; return;
          end
          e_n++;
        end
        e_ent = ne; e_rd = rd; e_wr = w;
        return;
      end
      base = e & ~64'hFFF;
    end
  endtask

  task automatic run_walk(input string tag, input logic [47:0] va, input bit wr,
                          input logic [15:0] fl);
    logic [63:0] e_ent, e_pa;
    int e_lvl, e_code, e_n;
    bit e_rd, e_wr, e_flt;
    model(va, wr, fl, req_root, e_ent, e_lvl, e_rd, e_wr, e_flt, e_code, e_n, e_pa);
    @(negedge clk);
    check({tag, " R1 ready before request"}, req_ready, 1);
    req_valid = 1'b1; req_addr = va; req_write = wr; req_pe_flags = fl;
    @(negedge clk);
    req_valid = 1'b0;
    for (int j = 0; j <= 2*e_n; j++) begin
      if (j > 0) @(negedge clk);
      check({tag, " R11 done timing"}, done, (j == 2*e_n));
      check({tag, " R11 mem request cycle"}, mem_req_valid, (j < 2*e_n && j % 2 == 0));
      check({tag, " R1 ready while busy"}, req_ready, 0);
      if (j == 2*e_n) begin
        check({tag, " R9 fault flag"}, res_fault, e_flt);
        check({tag, " R9 fault code"}, res_fault_code, e_code);
        check({tag, " R4 level"}, res_level, e_lvl);
        check({tag, " R8 entry"}, res_entry, e_ent);
        check({tag, " R3 read perm"}, res_read, e_rd);
        check({tag, " R3 write perm"}, res_write, e_wr);
      end
    end
    @(negedge clk);
    check({tag, " R11 done drops"}, done, 0);
    check({tag, " R1 ready again"}, req_ready, 1);
    if (!e_flt) check({tag, " R5 R8 leaf in memory"}, rd_mem(e_pa), e_ent);
  endtask

  // Table layout: root 0x10000 -> 0x20000 -> 0x30000 -> 0x40000
  localparam logic [47:0] VA1 = {9'd1, 9'd2, 9'd3, 9'd4, 12'h123};
  localparam logic [47:0] VA2 = {9'd1, 9'd5, 9'd6, 9'd7, 12'h0};
  localparam logic [63:0] LEAF1 = 64'h40000 + 4*8;

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; scalable_en = 1'b0; req_valid = 1'b0; req_addr = '0;
    req_write = 1'b0; req_pe_flags = '0; req_root = 64'h10000;
    mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_data = '0;
    mem[64'h10000 + 1*8] = 64'h20000 | 64'h83;   // bit 7 at top level ignored (R4)
    mem[64'h20000 + 2*8] = 64'h30000 | 64'h3;
    mem[64'h30000 + 3*8] = 64'h40000 | 64'h3;
    mem[LEAF1]           = 64'h5000_0000 | 64'h3;
    mem[64'h20000 + 5*8] = 64'h7000_0000 | 64'h83; // large leaf at level 3
    repeat (3) @(negedge clk);
    check("R1 reset ready", req_ready, 1);
    check("R1 reset done", done, 0);
    check("R1 reset mem valid", mem_req_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 cap off", ext_cap, 64'd0);
    scalable_en = 1'b1;
    #1 check("R10 cap on", ext_cap, 64'd1 << 45);

    run_walk("R7 read sets A", VA1, 1'b0, 16'h0200);
    run_walk("R6 write sets D", VA1, 1'b1, 16'h0200);
    run_walk("R8 no change no write", VA1, 1'b1, 16'h0200);
    mem[LEAF1] = 64'h5000_0000 | 64'h3;
    run_walk("R5 tracking off", VA1, 1'b1, 16'hFDFF);
    mem[64'h30000 + 3*8] = 64'h40000 | 64'h1;      // W removed at level 2
    run_walk("R6 no write perm", VA1, 1'b1, 16'h0200);
    run_walk("R7 read after perm loss", VA1, 1'b0, 16'h0200);
    mem[64'h30000 + 3*8] = 64'h40000 | 64'h3;
    mem[LEAF1] = 64'h5000_0000 | 64'h3;
    run_walk("R2 R4 large leaf", VA2, 1'b1, 16'h0200);
    err_addr = 64'h10000 + 8; err_wr_only = 1'b0;
    run_walk("R9 top fetch error", VA1, 1'b0, 16'h0200);
    err_addr = LEAF1;
    run_walk("R9 low fetch error", VA1, 1'b0, 16'h0200);
    err_wr_only = 1'b1;
    run_walk("R9 write-back error", VA1, 1'b1, 16'h0200);
    check("R5 leaf untouched after failed write", rd_mem(LEAF1), 64'h5000_0003);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule